// File: doc/BRIEF.md
# DMA Global and Channel Enable Control

This block owns the enable state of a multi-channel DMA engine. It holds a single global enable bit, one enable bit per channel, and four banks of per-channel software request bits (source burst, destination burst, source last, destination last). Software reaches all of them through a simple register port. Every bank that has per-channel bits is written through a write-enable byte, so one channel can be changed without a read-modify-write.

Hardware feeds back a one-cycle transfer-complete pulse per channel, which clears that channel's enable. It also feeds back a per-channel idle flag. When software drops the global enable, every channel enable falls at once. The global enable still reads back as set until every channel reports idle, so software can poll it to learn when the engine has fully drained.

Software request bits reach the channel only when the channel is enabled and software handshaking is selected for that side. The last-request bits also need that side to be the flow controller. Each request bit clears itself when the channel acknowledges that side or when the channel is disabled. The data path of each channel lies outside this block.

Top module: `dma_chan_enable_ctrl`

## Requirements
- R1: On a write to the channel-enable register (select 1), enable bit i takes data bit i only when data bit 8+i is 1. A write with an upper byte of zero changes no enable.
- R2: While the global enable is 0, every channel enable is 0. Writes to the channel-enable register are ignored, and reading it returns 0, including after the global enable is later set again.
- R3: The global enable register (select 0, bit 0) reads 1 after software clears it, for as long as any channel idle flag is 0. It reads 0 one clock after all idle flags are 1. If all channels are idle when it is cleared, it reads 0 right away.
- R4: A transfer-complete pulse on channel i clears that channel's enable on the next clock edge.
- R5: A request bit i (selects 2 to 5, data bit i with write enable in bit 8+i) is written only when channel i is enabled at the time of the write.
- R6: A source request bit (selects 2 and 4) is ignored unless source software handshaking is selected for that channel. A destination request bit (selects 3 and 5) is ignored unless destination software handshaking is selected.
- R7: A last-request bit (select 4 for source, 5 for destination) is also ignored unless that side of the channel is the flow controller.
- R8: A request bit clears on the clock edge after an acknowledge pulse for its channel and side.
- R9: All request bits of a channel clear when its enable goes to 0, whether by a channel write, completion or global disable.
- R10: After reset, every enable, request bit and readback value is 0.
- R11: Readback is combinational from register state. The selected bank appears in the low byte and the upper byte reads 0. Select 0 returns the global enable as seen by software in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wsel_i | input | 3 | Register select for the write |
| reg_wdata_i | input | 16 | Write data: upper byte is per-channel write enable, lower byte is the value |
| reg_rsel_i | input | 3 | Register select for readback |
| reg_rdata_o | output | 16 | Readback data |
| ch_done_i | input | 8 | Per-channel transfer-complete pulse |
| ch_idle_i | input | 8 | Per-channel idle flag |
| src_sw_hs_i | input | 8 | Source side uses software handshaking |
| dst_sw_hs_i | input | 8 | Destination side uses software handshaking |
| src_is_fc_i | input | 8 | Source side is the flow controller |
| dst_is_fc_i | input | 8 | Destination side is the flow controller |
| src_ack_i | input | 8 | Source request acknowledge pulse |
| dst_ack_i | input | 8 | Destination request acknowledge pulse |
| glb_en_o | output | 1 | Global enable as applied to the channels |
| ch_en_o | output | 8 | Channel enables |
| src_req_o | output | 8 | Software source burst requests |
| dst_req_o | output | 8 | Software destination burst requests |
| src_last_o | output | 8 | Software source last requests |
| dst_last_o | output | 8 | Software destination last requests |

## Verification
Every write, completion pulse and acknowledge lands at one clock edge. Its effect is due in the state and outputs right after that edge, and readback follows with no further delay because it is combinational. The bench drives inputs on the falling edge, lets one rising edge pass, and samples ports and readback on the next falling edge. The drain rule of R3 is checked both before and after the idle flags rise, one edge apart, so that a readback that falls early and one that never falls are both caught.

// File: rtl/dma_en_pkg.sv
package dma_en_pkg;

    typedef enum logic [2:0] {
        SEL_GLB   = 3'd0,
        SEL_CHEN  = 3'd1,
        SEL_SREQ  = 3'd2,
        SEL_DREQ  = 3'd3,
        SEL_SLAST = 3'd4,
        SEL_DLAST = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic drain;
    } glb_state_t;

endpackage

// File: rtl/dma_en_global.sv
module dma_en_global #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wbit_i,
    input  logic [NUM_CH-1:0] idle_i,
    output logic              en_q_o,
    output logic              en_d_o,
    output logic              rd_o
);
    import dma_en_pkg::*;

    glb_state_t st_d, st_q;
    logic       all_idle;

    always_comb begin
        all_idle = &idle_i;
        st_d     = st_q;
        if (wr_i) begin
            st_d.en    = wbit_i;
            st_d.drain = wbit_i ? 1'b0 : (st_q.drain | st_q.en);
        end
        if (all_idle) begin
            st_d.drain = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q_o = st_q.en;
    assign en_d_o = st_d.en;
    assign rd_o   = st_q.en | st_q.drain;

    // R3: software view only falls once all channels were idle
    p_rd_falls_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_o) |-> $past(all_idle));

    // R3: while draining and not idle, the view stays set
    p_drain_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && !all_idle && !wr_i) |=> rd_o);

endmodule

// File: rtl/dma_en_chan.sv
module dma_en_chan #(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [2*NUM_CH-1:0] wdata_i,
    input  logic                glb_q_i,
    input  logic                glb_d_i,
    input  logic [NUM_CH-1:0]   done_i,
    output logic [NUM_CH-1:0]   en_q_o,
    output logic [NUM_CH-1:0]   en_d_o
);
    logic [NUM_CH-1:0] en_d, en_q;
    logic [NUM_CH-1:0] we, val;

    always_comb begin
        we   = wdata_i[2*NUM_CH-1:NUM_CH];
        val  = wdata_i[NUM_CH-1:0];
        en_d = en_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!glb_d_i) begin
                en_d[i] = 1'b0;
            end else if (wr_i && glb_q_i && we[i]) begin
                en_d[i] = val[i];
            end else if (done_i[i]) begin
                en_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_q_o = en_q;
    assign en_d_o = en_d;

    // R2: no channel runs while global enable is low
    p_off_when_glb_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_q_i |-> (en_q == '0));

    // R1: empty write-enable byte leaves enables alone
    p_no_we_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (wdata_i[2*NUM_CH-1:NUM_CH] == '0) && (done_i == '0) && glb_d_i)
        |=> $stable(en_q));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4: completion clears the enable
        p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i[g] && !(wr_i && wdata_i[NUM_CH+g])) |=> !en_q[g]);
    end

endmodule

// File: rtl/dma_en_swreq.sv
module dma_en_swreq #(
    parameter int NUM_CH  = 8,
    parameter bit NEED_FC = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [2*NUM_CH-1:0] wdata_i,
    input  logic [NUM_CH-1:0]   ch_en_q_i,
    input  logic [NUM_CH-1:0]   ch_en_d_i,
    input  logic [NUM_CH-1:0]   sw_hs_i,
    input  logic [NUM_CH-1:0]   is_fc_i,
    input  logic [NUM_CH-1:0]   ack_i,
    output logic [NUM_CH-1:0]   req_o
);
    logic [NUM_CH-1:0] req_d, req_q;
    logic [NUM_CH-1:0] accept, fc_gate, we, val;

    generate
        if (NEED_FC) begin : g_fc
            assign fc_gate = is_fc_i;
        end else begin : g_nofc
            assign fc_gate = '1;
        end
    endgenerate

    always_comb begin
        we     = wdata_i[2*NUM_CH-1:NUM_CH];
        val    = wdata_i[NUM_CH-1:0];
        accept = ch_en_q_i & sw_hs_i & fc_gate;
        req_d  = req_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!ch_en_d_i[i]) begin
                req_d[i] = 1'b0;
            end else if (wr_i && we[i] && accept[i]) begin
                req_d[i] = val[i];
            end else if (ack_i[i]) begin
                req_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_o = req_q;

    // R5 / R9: a request never outlives its channel enable
    p_req_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q & ~ch_en_q_i) == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8: acknowledge clears the request
        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[g] && !(wr_i && wdata_i[NUM_CH+g])) |=> !req_q[g]);
        // R6: no set without software handshaking
        p_hs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_hs_i[g] && !req_q[g]) |=> !req_q[g]);
    end

endmodule

// File: rtl/dma_chan_enable_ctrl.sv
module dma_chan_enable_ctrl #(
    parameter int NUM_CH = 8,
    localparam int DW    = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [2:0]        reg_wsel_i,
    input  logic [DW-1:0]     reg_wdata_i,
    input  logic [2:0]        reg_rsel_i,
    output logic [DW-1:0]     reg_rdata_o,
    input  logic [NUM_CH-1:0] ch_done_i,
    input  logic [NUM_CH-1:0] ch_idle_i,
    input  logic [NUM_CH-1:0] src_sw_hs_i,
    input  logic [NUM_CH-1:0] dst_sw_hs_i,
    input  logic [NUM_CH-1:0] src_is_fc_i,
    input  logic [NUM_CH-1:0] dst_is_fc_i,
    input  logic [NUM_CH-1:0] src_ack_i,
    input  logic [NUM_CH-1:0] dst_ack_i,
    output logic              glb_en_o,
    output logic [NUM_CH-1:0] ch_en_o,
    output logic [NUM_CH-1:0] src_req_o,
    output logic [NUM_CH-1:0] dst_req_o,
    output logic [NUM_CH-1:0] src_last_o,
    output logic [NUM_CH-1:0] dst_last_o
);
    import dma_en_pkg::*;

    localparam int NBANK = 4;

    logic              glb_q, glb_d, glb_rd;
    logic [NUM_CH-1:0] en_q, en_d;
    logic [NBANK-1:0]  bank_wr;
    logic [NUM_CH-1:0] bank_q   [NBANK];
    logic [NUM_CH-1:0] bank_hs  [NBANK];
    logic [NUM_CH-1:0] bank_fc  [NBANK];
    logic [NUM_CH-1:0] bank_ack [NBANK];

    dma_en_global #(.NUM_CH(NUM_CH)) u_glb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr_i && (reg_wsel_i == SEL_GLB)),
        .wbit_i (reg_wdata_i[0]),
        .idle_i (ch_idle_i),
        .en_q_o (glb_q),
        .en_d_o (glb_d),
        .rd_o   (glb_rd)
    );

    dma_en_chan #(.NUM_CH(NUM_CH)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i && (reg_wsel_i == SEL_CHEN)),
        .wdata_i (reg_wdata_i),
        .glb_q_i (glb_q),
        .glb_d_i (glb_d),
        .done_i  (ch_done_i),
        .en_q_o  (en_q),
        .en_d_o  (en_d)
    );

    // bank b: even = source side, odd = destination side, b>=2 = last request
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_wr[b]  = reg_wr_i && (reg_wsel_i == 3'(b + 2));
        assign bank_hs[b]  = (b % 2 == 0) ? src_sw_hs_i : dst_sw_hs_i;
        assign bank_fc[b]  = (b % 2 == 0) ? src_is_fc_i : dst_is_fc_i;
        assign bank_ack[b] = (b % 2 == 0) ? src_ack_i   : dst_ack_i;

        dma_en_swreq #(.NUM_CH(NUM_CH), .NEED_FC(b >= 2)) u_req (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (bank_wr[b]),
            .wdata_i   (reg_wdata_i),
            .ch_en_q_i (en_q),
            .ch_en_d_i (en_d),
            .sw_hs_i   (bank_hs[b]),
            .is_fc_i   (bank_fc[b]),
            .ack_i     (bank_ack[b]),
            .req_o     (bank_q[b])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_rsel_i)
            SEL_GLB:   reg_rdata_o[0]        = glb_rd;
            SEL_CHEN:  reg_rdata_o[NUM_CH-1:0] = en_q;
            SEL_SREQ:  reg_rdata_o[NUM_CH-1:0] = bank_q[0];
            SEL_DREQ:  reg_rdata_o[NUM_CH-1:0] = bank_q[1];
            SEL_SLAST: reg_rdata_o[NUM_CH-1:0] = bank_q[2];
            SEL_DLAST: reg_rdata_o[NUM_CH-1:0] = bank_q[3];
            default:   reg_rdata_o           = '0;
        endcase
    end

    assign glb_en_o   = glb_q;
    assign ch_en_o    = en_q;
    assign src_req_o  = bank_q[0];
    assign dst_req_o  = bank_q[1];
    assign src_last_o = bank_q[2];
    assign dst_last_o = bank_q[3];

    // R11: upper byte of readback is always zero
    p_rd_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[DW-1:NUM_CH] == '0);

    // R7: last requests only stand where that side controls flow
    p_last_fc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_is_fc_i[0] && !bank_q[2][0]) |=> !bank_q[2][0]);

endmodule

// File: tb/tb_dma_chan_enable_ctrl.sv
module tb_dma_chan_enable_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_wsel = '0, reg_rsel = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [N-1:0] done = '0, idle = '1, shs = '0, dhs = '0, sfc = '0, dfc = '0;
    logic [N-1:0] sack = '0, dack = '0;
    logic glb_en;
    logic [N-1:0] ch_en, sreq, dreq, slast, dlast;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_enable_ctrl #(.NUM_CH(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_wsel_i(reg_wsel), .reg_wdata_i(reg_wdata),
        .reg_rsel_i(reg_rsel), .reg_rdata_o(reg_rdata),
        .ch_done_i(done), .ch_idle_i(idle),
        .src_sw_hs_i(shs), .dst_sw_hs_i(dhs), .src_is_fc_i(sfc), .dst_is_fc_i(dfc),
        .src_ack_i(sack), .dst_ack_i(dack),
        .glb_en_o(glb_en), .ch_en_o(ch_en), .src_req_o(sreq), .dst_req_o(dreq),
        .src_last_o(slast), .dst_last_o(dlast)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [2:0] sel, input logic [15:0] exp);
        reg_rsel = sel;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_wsel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int s = 0; s < 6; s++) rd("R10", 3'(s), 16'h0);
        chk("R10", {glb_en, ch_en, sreq}, 17'h0);
        chk("R10", {dreq, slast, dlast}, 24'h0);

        // R2: writes ignored while global off, still 0 after enabling
        wr(3'd1, 16'hFFFF);
        rd("R2", 3'd1, 16'h0);
        wr(3'd0, 16'h0001);
        rd("R3", 3'd0, 16'h0001);
        chk("R2", ch_en, 8'h00);

        // R1: sweep every write-enable byte
        exp_en = 8'h00;
        for (int k = 0; k < 256; k++) begin
            logic [7:0] d;
            d = 8'((k * 7 + 3) ^ (k >> 2));
            wr(3'd1, {8'(k), d});
            exp_en = (exp_en & ~8'(k)) | (d & 8'(k));
            rd("R1", 3'd1, {8'h00, exp_en});
            chk("R1", ch_en, exp_en);
        end

        // R4: completion pulse on each channel in turn
        wr(3'd1, 16'hFFFF);
        exp_en = 8'hFF;
        for (int i = 0; i < N; i++) begin
            @(negedge clk); done = 8'(1 << i);
            @(negedge clk); done = '0;
            exp_en[i] = 1'b0;
            chk("R4", ch_en, exp_en);
        end

        // R5 R6 R7: request gating sweep over all four banks
        for (int t = 0; t < 4; t++) begin
            for (int p = 0; p < 16; p++) begin
                logic [7:0] en, hs, fc, exp;
                en = 8'(p * 8'h35) ^ 8'hA5;
                hs = 8'(p * 8'h5B) ^ 8'h3C;
                fc = 8'(p * 8'h1D) ^ 8'hC3;
                shs = hs; dhs = hs; sfc = fc; dfc = fc;
                wr(3'd1, {8'hFF, en});
                wr(3'(t + 2), 16'hFFFF);
                exp = en & hs & ((t >= 2) ? fc : 8'hFF);
                rd((t >= 2) ? "R7" : "R5", 3'(t + 2), {8'h00, exp});
                chk("R6", (t == 0) ? sreq : (t == 1) ? dreq : (t == 2) ? slast : dlast, exp);
                wr(3'(t + 2), 16'hFF00);
                rd("R5", 3'(t + 2), 16'h0);
            end
        end

        // R8: acknowledge clears requests on its side only
        shs = '1; dhs = '1; sfc = '1; dfc = '1;
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        @(negedge clk); sack = 8'h0F;
        @(negedge clk); sack = '0;
        chk("R8", sreq, 8'hF0);
        chk("R8", dlast, 8'hFF);
        @(negedge clk); dack = 8'hAA;
        @(negedge clk); dack = '0;
        chk("R8", dlast, 8'h55);
        chk("R8", sreq, 8'hF0);

        // R9: channel write and global disable clear requests
        wr(3'd1, 16'h3000);
        chk("R9", sreq, 8'hC0);
        chk("R9", dlast, 8'h45);
        wr(3'd0, 16'h0000);
        chk("R9", {sreq, dlast}, 16'h0);
        chk("R2", ch_en, 8'h00);
        rd("R3", 3'd0, 16'h0);
        chk("R2", glb_en, 1'b0);

        // R3: drain hold
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'hFFFF);
        idle = 8'hFE;
        wr(3'd0, 16'h0000);
        rd("R3", 3'd0, 16'h0001);
        rd("R2", 3'd1, 16'h0000);
        chk("R3", glb_en, 1'b0);
        @(negedge clk);
        rd("R3", 3'd0, 16'h0001);
        idle = 8'hFF;
        @(negedge clk);
        rd("R3", 3'd0, 16'h0000);

        // R11: unused selects read 0
        rd("R11", 3'd6, 16'h0);
        rd("R11", 3'd7, 16'h0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule